// File: doc/BRIEF.md
# SPI Manual-Mode Operation Sequencer

This block is an SPI master that software steers one queued operation word at a time. Each word carries a 5-bit opcode and a 9-bit byte count. It either sets the chip-select level or runs a stream of bytes out of or into the block on one, two or four data lanes. Transmit bytes come from a byte-wide data FIFO that software fills. Received bytes land in the same FIFO, and software reads them from there and pops them.

A small register bus has a write strobe, a 3-bit address and a 14-bit write-data field. Writes stage an operation word, commit it, push a data byte and pop the head byte. Combinational reads return the head byte and the status flags. A transfer longer than 511 bytes is issued as several operations. The serial side runs SPI mode 0 at half the block clock. SCK idles low, output data changes while SCK is low, and input lanes are sampled on the rising SCK edge, most significant bits first.

Top module: `spi_opseq`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0 and io_oe_o is 0. Read address 1 (queue drained) returns 1 in bit 0. Read address 4 (data FIFO empty) returns 1 in bit 0.
- R2: A write to address 0 stages an operation word, with the byte count in bits 8..0 and the opcode in bits 13..9. A write to address 1 with bit 0 = 1 commits the staged word to the operation FIFO. A write to address 1 with bit 0 = 0 commits nothing.
- R3: Opcode 0x00 drives cs_n_o to 1 and opcode 0x01 drives it to 0. Neither produces an SCK pulse.
- R4: Opcodes 0x08, 0x09 and 0x0A transmit count bytes taken from the data FIFO on one, two or four lanes.
  - The lanes are io_o_o[0], io_o_o[1:0] and io_o_o[3:0], with the most significant bits first.
  - io_oe_o is 0001, 0011 or 1111 respectively.
  - Exactly count*8/width SCK pulses are produced.
- R5: Opcodes 0x0C, 0x0E and 0x0F receive count bytes into the data FIFO, with io_oe_o at 0000.
  - They sample io_i[1], io_i[1:0] or io_i[3:0] respectively, at each SCK rise, most significant bits first.
  - Read address 0 returns the head byte. A write to address 3 with bit 0 = 1 pops it.
- R6: A transmit operation holds SCK low while the data FIFO is empty. A receive operation holds SCK low while the data FIFO is full. Both resume when the condition clears, and no byte is lost.
- R7: Read address 1 bit 0 is 0 while any operation is queued or executing. It is 1 once all queued operations have completed.
- R8: SCK idles low and never stays high for more than one clock. cs_n_o changes only while SCK is low.
- R9: Operations are consumed without any SCK pulse, chip-select change or data FIFO access in two cases:
  - an operation whose opcode is not one of the eight above;
  - a transfer opcode with a count of 0.
- R10: A write to address 2 pushes bits 7..0 into the data FIFO. Read address 3 bit 0 is the data FIFO full flag. Read address 2 bit 0 is the operation FIFO full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | 14 | Register write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| io_o_o | output | 4 | Data lane output values |
| io_oe_o | output | 4 | Data lane output enables |
| io_i | input | 4 | Data lane input values |

## Verification
Two functions can fall in the same cycle:
- the engine popping a transmit byte from the data FIFO;
- software pushing the next byte into it.

To provoke this, a 20-byte transmit starts with an empty data FIFO. Software then feeds bytes one at a time, gated only by the full flag, so pushes land on arbitrary cycles, some of them on the engine's fetch cycle. The result is judged at the pins: the captured serial stream must equal the pushed sequence byte for byte, with exactly 160 SCK pulses. An operation commit that coincides with the engine fetching the previous word is judged the same way, by the chip-select and transfer order seen at the pins.

// File: rtl/spi_opseq_pkg.sv
package spi_opseq_pkg;

    localparam int LEN_W     = 9;
    localparam int OPC_W     = 5;
    localparam int OPWORD_W  = LEN_W + OPC_W;

    localparam logic [2:0] A_STAGE  = 3'd0;
    localparam logic [2:0] A_COMMIT = 3'd1;
    localparam logic [2:0] A_DPUSH  = 3'd2;
    localparam logic [2:0] A_DPOP   = 3'd3;
    localparam logic [2:0] A_HEAD   = 3'd0;
    localparam logic [2:0] A_DRAIN  = 3'd1;
    localparam logic [2:0] A_OFULL  = 3'd2;
    localparam logic [2:0] A_DFULL  = 3'd3;
    localparam logic [2:0] A_DEMPTY = 3'd4;

    typedef enum logic [1:0] {LANE1, LANE2, LANE4} lane_e;
    typedef enum logic [2:0] {K_NONE, K_CSH, K_CSL, K_TX, K_RX} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_LO, S_HI} state_e;

    typedef struct packed {
        kind_e             kind;
        lane_e             lane;
        logic [LEN_W-1:0]  len;
    } op_t;

    function automatic op_t decode_op(logic [OPWORD_W-1:0] w);
        op_t o;
        o.len  = w[LEN_W-1:0];
        o.lane = LANE1;
        o.kind = K_NONE;
        case (w[OPWORD_W-1:LEN_W])
            5'h00: o.kind = K_CSH;
            5'h01: o.kind = K_CSL;
            5'h08: o.kind = K_TX;
            5'h09: begin o.kind = K_TX; o.lane = LANE2; end
            5'h0A: begin o.kind = K_TX; o.lane = LANE4; end
            5'h0C: o.kind = K_RX;
            5'h0E: begin o.kind = K_RX; o.lane = LANE2; end
            5'h0F: begin o.kind = K_RX; o.lane = LANE4; end
            default: o.kind = K_NONE;
        endcase
        return o;
    endfunction

    function automatic logic [2:0] last_beat(lane_e l);
        case (l)
            LANE2:   return 3'd3;
            LANE4:   return 3'd1;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [7:0] shift_lane(logic [7:0] sr, logic [3:0] io, lane_e l);
        case (l)
            LANE2:   return {sr[5:0], io[1:0]};
            LANE4:   return {sr[3:0], io};
            default: return {sr[6:0], io[1]};
        endcase
    endfunction

    function automatic logic [3:0] drive_lane(logic [7:0] sr, lane_e l);
        case (l)
            LANE2:   return {2'b00, sr[7:6]};
            LANE4:   return sr[7:4];
            default: return {3'b000, sr[7]};
        endcase
    endfunction

    function automatic logic [3:0] oe_mask(lane_e l);
        case (l)
            LANE2:   return 4'b0011;
            LANE4:   return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/opseq_fifo.sv
module opseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r10_full_drops: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && full) |=> full);
    a_r10_empty_holds: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> empty);

endmodule

// File: rtl/opseq_engine.sv
module opseq_engine
    import spi_opseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [OPWORD_W-1:0] op_word,
    output logic                op_pop,
    input  logic [7:0]          d_head,
    input  logic                d_empty,
    input  logic                d_full,
    output logic                d_pop,
    output logic                d_push,
    output logic [7:0]          d_wdata,
    input  logic [3:0]          io_i,
    output logic                sck,
    output logic                cs_n,
    output logic [3:0]          io_o,
    output logic [3:0]          io_oe,
    output logic                busy
);
    state_e           state;
    kind_e            kind;
    lane_e            lane;
    logic [LEN_W-1:0] remain;
    logic [2:0]       beat;
    logic [7:0]       sr;
    logic             sck_q, cs_q;
    op_t              nxt;

    assign nxt     = decode_op(op_word);
    assign op_pop  = (state == S_IDLE) && op_valid;
    assign d_pop   = (state == S_LOAD) && (kind == K_TX) && (remain != '0) && !d_empty;
    assign d_push  = (state == S_HI) && (kind == K_RX) && (beat == 3'd0);
    assign d_wdata = sr;
    assign sck     = sck_q;
    assign cs_n    = cs_q;
    assign busy    = (state != S_IDLE);
    assign io_o    = (kind == K_TX) ? drive_lane(sr, lane) : 4'b0000;
    assign io_oe   = (kind == K_TX && state != S_IDLE) ? oe_mask(lane) : 4'b0000;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            kind   <= K_NONE;
            lane   <= LANE1;
            remain <= '0;
            beat   <= '0;
            sr     <= '0;
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            case (state)
                S_IDLE: if (op_valid) begin
                    case (nxt.kind)
                        K_CSH: cs_q <= 1'b1;
                        K_CSL: cs_q <= 1'b0;
                        K_TX, K_RX: if (nxt.len != '0) begin
                            kind   <= nxt.kind;
                            lane   <= nxt.lane;
                            remain <= nxt.len;
                            state  <= S_LOAD;
                        end
                        default: ;
                    endcase
                end
                S_LOAD: begin
                    if (remain == '0) begin
                        state <= S_IDLE;
                        kind  <= K_NONE;
                    end else if (kind == K_TX && !d_empty) begin
                        sr    <= d_head;
                        beat  <= last_beat(lane);
                        state <= S_LO;
                    end else if (kind == K_RX && !d_full) begin
                        beat  <= last_beat(lane);
                        state <= S_LO;
                    end
                end
                S_LO: begin
                    sck_q <= 1'b1;
                    state <= S_HI;
                    if (kind == K_RX)
                        sr <= shift_lane(sr, io_i, lane);
                end
                S_HI: begin
                    sck_q <= 1'b0;
                    if (kind == K_TX)
                        sr <= shift_lane(sr, 4'b0000, lane);
                    if (beat == 3'd0) begin
                        remain <= remain - 1'b1;
                        state  <= S_LOAD;
                    end else begin
                        beat  <= beat - 1'b1;
                        state <= S_LO;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    a_r8_single_high: assert property (@(posedge clk) disable iff (rst)
        sck_q |=> !sck_q);
    a_r8_cs_with_sck_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_q) |-> !sck_q);
    a_r6_rx_no_overflow: assert property (@(posedge clk) disable iff (rst)
        d_push |-> !d_full);
    a_r6_tx_stall_low: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD && kind == K_TX && d_empty) |=> !sck_q);

endmodule

// File: rtl/spi_opseq.sv
module spi_opseq
    import spi_opseq_pkg::*;
#(
    parameter int OP_DEPTH   = 4,
    parameter int DATA_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [2:0]          bus_addr,
    input  logic [OPWORD_W-1:0] bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic                sck_o,
    output logic                cs_n_o,
    output logic [3:0]          io_o_o,
    output logic [3:0]          io_oe_o,
    input  logic [3:0]          io_i
);
    logic [OPWORD_W-1:0] staged;
    logic [OPWORD_W-1:0] op_head;
    logic                sw_op_push, sw_d_push, sw_d_pop;
    logic                op_empty, op_full, op_pop;
    logic                d_empty, d_full, eng_pop, eng_push, busy;
    logic [7:0]          d_head, eng_wdata;
    logic                drained;

    assign sw_op_push = bus_wr && bus_addr == A_COMMIT && bus_wdata[0];
    assign sw_d_push  = bus_wr && bus_addr == A_DPUSH;
    assign sw_d_pop   = bus_wr && bus_addr == A_DPOP && bus_wdata[0];
    assign drained    = op_empty && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            staged <= '0;
        else if (bus_wr && bus_addr == A_STAGE)
            staged <= bus_wdata;
    end

    always_comb begin
        case (bus_addr)
            A_HEAD:   bus_rdata = d_head;
            A_DRAIN:  bus_rdata = {7'b0, drained};
            A_OFULL:  bus_rdata = {7'b0, op_full};
            A_DFULL:  bus_rdata = {7'b0, d_full};
            A_DEMPTY: bus_rdata = {7'b0, d_empty};
            default:  bus_rdata = 8'h00;
        endcase
    end

    opseq_fifo #(.W(OPWORD_W), .DEPTH(OP_DEPTH)) u_opq (
        .clk(clk), .rst(rst), .push(sw_op_push), .din(staged), .pop(op_pop),
        .head(op_head), .empty(op_empty), .full(op_full)
    );

    opseq_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_dq (
        .clk(clk), .rst(rst), .push(eng_push || sw_d_push),
        .din(eng_push ? eng_wdata : bus_wdata[7:0]), .pop(eng_pop || sw_d_pop),
        .head(d_head), .empty(d_empty), .full(d_full)
    );

    opseq_engine u_eng (
        .clk(clk), .rst(rst), .op_valid(!op_empty), .op_word(op_head), .op_pop(op_pop),
        .d_head(d_head), .d_empty(d_empty), .d_full(d_full), .d_pop(eng_pop),
        .d_push(eng_push), .d_wdata(eng_wdata), .io_i(io_i), .sck(sck_o),
        .cs_n(cs_n_o), .io_o(io_o_o), .io_oe(io_oe_o), .busy(busy)
    );

    a_r7_drained_quiet: assert property (@(posedge clk) disable iff (rst)
        (drained && !sw_op_push) |=> !sck_o);

endmodule

// File: tb/spi_opseq_tb.sv
module spi_opseq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [13:0] bus_wdata = 14'd0;
    logic [7:0]  bus_rdata;
    logic        sck_o, cs_n_o;
    logic [3:0]  io_o_o, io_oe_o, io_i;

    spi_opseq u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o),
        .cs_n_o(cs_n_o), .io_o_o(io_o_o), .io_oe_o(io_oe_o), .io_i(io_i)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench-side configuration, written only by the initial block
    int tx_mode = 0;
    int tx_w = 1;
    int rx_w = 1;
    int rx_base = 0;

    // monitors, written only by the always blocks below
    int sck_rises = 0;
    int rx_beat = 0;
    int cap_n = 0;
    int oe_bad = 0;
    int cs_bad = 0;
    int cs_sck_bad = 0;
    logic [7:0] cap [0:255];
    logic [7:0] acc = 8'd0;
    int bitn = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end

    always @(posedge sck_o) begin
        sck_rises++;
        if (cs_n_o) cs_bad++;
        if (tx_mode != 0) begin
            if (io_oe_o != ((tx_w == 1) ? 4'b0001 : (tx_w == 2) ? 4'b0011 : 4'b1111)) oe_bad++;
            case (tx_w)
                2: acc = {acc[5:0], io_o_o[1:0]};
                4: acc = {acc[3:0], io_o_o[3:0]};
                default: acc = {acc[6:0], io_o_o[0]};
            endcase
            bitn += tx_w;
            if (bitn >= 8) begin
                cap[cap_n[7:0]] = acc;
                cap_n++;
                bitn = 0;
            end
        end else if (io_oe_o != 4'b0000) oe_bad++;
    end

    always @(negedge sck_o) rx_beat++;

    always @(cs_n_o) if (sck_o) cs_sck_bad++;

    function automatic logic [7:0] rxpat(int k);
        return 8'((k * 53 + 27) & 255);
    endfunction

    function automatic logic [7:0] txpat(int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    always_comb begin
        int bpb, idx, ch, v;
        bpb = 8 / rx_w;
        idx = rx_beat - rx_base;
        ch  = idx % bpb;
        v   = (int'(rxpat(idx / bpb)) >> (8 - rx_w * (ch + 1))) & ((1 << rx_w) - 1);
        if (rx_w == 1) io_i = {2'b00, v[0], 1'b0};
        else           io_i = v[3:0];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [13:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic push_op(input int opc, input int len);
        wr(3'd0, {opc[4:0], len[8:0]});
        wr(3'd1, 14'd1);
    endtask

    task automatic wait_drained(input string req);
        logic [7:0] v;
        int n;
        n = 0;
        v = 8'd0;
        while (v[0] == 1'b0 && n < 20000) begin
            rd(3'd1, v);
            n++;
        end
        check(v[0] == 1'b1, req, int'(v[0]), 1);
    endtask

    function automatic int txopc(int w);
        return (w == 1) ? 8 : (w == 2) ? 9 : 10;
    endfunction

    function automatic int rxopc(int w);
        return (w == 1) ? 12 : (w == 2) ? 14 : 15;
    endfunction

    initial begin
        logic [7:0] v;
        int s0, c0, seed;
        seed = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(cs_n_o == 1'b1, "R1 cs_n", int'(cs_n_o), 1);
        check(sck_o == 1'b0, "R1 sck", int'(sck_o), 0);
        check(io_oe_o == 4'b0, "R1 oe", int'(io_oe_o), 0);
        rd(3'd1, v); check(v[0] == 1'b1, "R1 drained", int'(v[0]), 1);
        rd(3'd4, v); check(v[0] == 1'b1, "R1 data empty", int'(v[0]), 1);

        // R2 commit with bit0 = 0 does nothing
        wr(3'd0, {5'h01, 9'd1});
        wr(3'd1, 14'd0);
        repeat (10) @(negedge clk);
        check(cs_n_o == 1'b1, "R2 ignored commit", int'(cs_n_o), 1);
        rd(3'd1, v); check(v[0] == 1'b1, "R2 drained after ignored commit", int'(v[0]), 1);
        wr(3'd1, 14'd1);
        wait_drained("R2 drain");
        check(cs_n_o == 1'b0, "R3 cs low", int'(cs_n_o), 0);
        push_op(0, 1);
        wait_drained("R3 drain");
        check(cs_n_o == 1'b1, "R3 cs high", int'(cs_n_o), 1);

        // R4 transmit sweep
        tx_mode = 1;
        for (int wi = 0; wi < 3; wi++) begin
            for (int len = 1; len <= 6; len++) begin
                tx_w = 1 << wi;
                s0 = sck_rises; c0 = cap_n;
                for (int i = 0; i < len; i++) wr(3'd2, {6'd0, txpat(seed + i)});
                push_op(1, 1);
                push_op(txopc(tx_w), len);
                push_op(0, 1);
                wait_drained("R7 tx drain");
                check(sck_rises - s0 == len * 8 / tx_w, "R4 sck count", sck_rises - s0, len * 8 / tx_w);
                check(cap_n - c0 == len, "R4 byte count", cap_n - c0, len);
                for (int i = 0; i < len; i++)
                    check(cap[(c0 + i) & 255] == txpat(seed + i), "R4 tx byte",
                          int'(cap[(c0 + i) & 255]), int'(txpat(seed + i)));
                check(cs_n_o == 1'b1 && sck_o == 1'b0, "R8 idle after tx", int'(sck_o), 0);
                seed += len;
            end
        end

        // R5 receive sweep
        tx_mode = 0;
        for (int wi = 0; wi < 3; wi++) begin
            for (int len = 1; len <= 8; len += 3) begin
                rx_w = 1 << wi;
                rx_base = rx_beat;
                s0 = sck_rises;
                push_op(1, 1);
                push_op(rxopc(rx_w), len);
                push_op(0, 1);
                wait_drained("R7 rx drain");
                check(sck_rises - s0 == len * 8 / rx_w, "R5 sck count", sck_rises - s0, len * 8 / rx_w);
                for (int i = 0; i < len; i++) begin
                    rd(3'd0, v);
                    check(v == rxpat(i), "R5 rx byte", int'(v), int'(rxpat(i)));
                    wr(3'd3, 14'd1);
                end
                rd(3'd4, v); check(v[0] == 1'b1, "R5 fifo empty after reads", int'(v[0]), 1);
            end
        end

        // R6 transmit stall on empty data FIFO
        tx_mode = 1; tx_w = 1;
        s0 = sck_rises; c0 = cap_n;
        wr(3'd2, {6'd0, txpat(100)});
        push_op(1, 1);
        push_op(8, 3);
        push_op(0, 1);
        repeat (200) @(negedge clk);
        check(sck_rises - s0 == 8, "R6 tx stalled pulses", sck_rises - s0, 8);
        check(sck_o == 1'b0, "R6 sck low in stall", int'(sck_o), 0);
        rd(3'd1, v); check(v[0] == 1'b0, "R7 busy in stall", int'(v[0]), 0);
        wr(3'd2, {6'd0, txpat(101)});
        wr(3'd2, {6'd0, txpat(102)});
        wait_drained("R6 tx resume");
        check(sck_rises - s0 == 24, "R6 tx total pulses", sck_rises - s0, 24);
        for (int i = 0; i < 3; i++)
            check(cap[(c0 + i) & 255] == txpat(100 + i), "R6 tx byte",
                  int'(cap[(c0 + i) & 255]), int'(txpat(100 + i)));

        // R6 receive stall on full data FIFO
        tx_mode = 0; rx_w = 1; rx_base = rx_beat;
        s0 = sck_rises;
        push_op(1, 1);
        push_op(12, 10);
        push_op(0, 1);
        repeat (400) @(negedge clk);
        check(sck_rises - s0 == 64, "R6 rx stalled pulses", sck_rises - s0, 64);
        rd(3'd3, v); check(v[0] == 1'b1, "R10 data full flag", int'(v[0]), 1);
        rd(3'd1, v); check(v[0] == 1'b0, "R7 busy in rx stall", int'(v[0]), 0);
        for (int i = 0; i < 2; i++) begin
            rd(3'd0, v);
            check(v == rxpat(i), "R6 rx byte", int'(v), int'(rxpat(i)));
            wr(3'd3, 14'd1);
        end
        wait_drained("R6 rx resume");
        check(sck_rises - s0 == 80, "R6 rx total pulses", sck_rises - s0, 80);
        for (int i = 2; i < 10; i++) begin
            rd(3'd0, v);
            check(v == rxpat(i), "R6 rx byte", int'(v), int'(rxpat(i)));
            wr(3'd3, 14'd1);
        end

        // R9 unknown opcode and zero counts
        wr(3'd2, 14'h0A5);
        s0 = sck_rises;
        push_op(5, 3);
        push_op(8, 0);
        push_op(12, 0);
        wait_drained("R9 drain");
        repeat (5) @(negedge clk);
        check(sck_rises == s0, "R9 no pulses", sck_rises - s0, 0);
        check(cs_n_o == 1'b1, "R9 cs unchanged", int'(cs_n_o), 1);
        rd(3'd4, v); check(v[0] == 1'b0, "R9 data untouched", int'(v[0]), 0);
        rd(3'd0, v); check(v == 8'hA5, "R9 head byte", int'(v), 165);
        wr(3'd3, 14'd1);

        // R10 operation FIFO full while the engine stalls
        tx_mode = 1; tx_w = 1; c0 = cap_n;
        push_op(1, 1);
        push_op(8, 1);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 4; i++) push_op(0, 1);
        rd(3'd2, v); check(v[0] == 1'b1, "R10 op full flag", int'(v[0]), 1);
        wr(3'd2, {6'd0, txpat(200)});
        wait_drained("R10 drain");
        rd(3'd2, v); check(v[0] == 1'b0, "R10 op not full", int'(v[0]), 0);
        check(cap[c0 & 255] == txpat(200), "R10 tx byte", int'(cap[c0 & 255]), int'(txpat(200)));

        // same-cycle push and engine fetch on the data FIFO
        s0 = sck_rises; c0 = cap_n;
        push_op(1, 1);
        push_op(8, 20);
        push_op(0, 1);
        for (int i = 0; i < 20; i++) begin
            v = 8'd1;
            while (v[0]) rd(3'd3, v);
            wr(3'd2, {6'd0, txpat(300 + i)});
        end
        wait_drained("R4 stream drain");
        check(sck_rises - s0 == 160, "R4 stream pulses", sck_rises - s0, 160);
        for (int i = 0; i < 20; i++)
            check(cap[(c0 + i) & 255] == txpat(300 + i), "R4 stream byte",
                  int'(cap[(c0 + i) & 255]), int'(txpat(300 + i)));

        check(oe_bad == 0, "R5 output enables", oe_bad, 0);
        check(cs_bad == 0, "R3 cs low during pulses", cs_bad, 0);
        check(cs_sck_bad == 0, "R8 cs with sck low", cs_sck_bad, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule